// File: doc/BRIEF.md
# Release-ordered vector register store decoder

This unit sits in a load/store pipeline and looks at one 32-bit instruction word at a time. It picks out a single encoding: a store of one SIMD/FP register to memory, with release ordering and an unscaled signed byte offset. A matching word is sorted into one of four outcomes: a store, a trap (vector unit not enabled), an undefined-encoding flag, or a stack-pointer alignment fault. For a store, the unit forms the target address and the byte lanes, then captures the whole request.

The captured request is not presented at once. The unit first waits until the bench-visible count of earlier memory accesses that are still in flight reaches zero. Only then does it raise its store request, which it holds steady until the memory side accepts it. Register-file read data for the base and vector registers arrives alongside the instruction word. The unit drives the two read indices taken from the word, so the register file can supply that data in the same cycle.

Top module: `srv_store_decode`

## Requirements
- R1: A word is accepted only when instr_valid and instr_ready are both high, bits [29:24] equal 011101, bits [22:21] equal 00 and bits [11:10] equal 10. Any other word produces no store request and no flag.
- R2: The access scale is the 3-bit value {bit 23, bits [31:30]}. st_size carries that scale, and st_be has exactly the lowest 2^scale bits set (1, 2, 4, 8 or 16 bytes).
- R3: A matching word with scale above 4 (values 5, 6 or 7) raises undef_pulse and issues no store.
- R4: st_addr equals the base plus the 9-bit field in bits [20:12], sign-extended and not scaled (range -256 to +255).
- R5: Base register number 31 (bits [9:5]) selects sp_value as the base and drives st_tag_check low. Any other number selects base_data and drives st_tag_check high.
- R6: When the base register number is 31 and sp_value[3:0] is nonzero, the unit raises align_fault_pulse and issues no store. The value of sp_value has no effect for other base numbers.
- R7: When fp_enable is low, a matching word raises trap_pulse and issues no store. Priority is trap, then undefined, then alignment fault, and at most one flag is raised per word.
- R8: st_valid rises only after a clock edge at which outstanding_cnt was zero. It stays low while outstanding_cnt is nonzero.
- R9: While st_valid is high and st_ready is low, st_valid, st_addr, st_data, st_be, st_size and st_tag_check hold their values.
- R10: st_data carries the low 8*2^scale bits of vec_data, with all higher bits zero.
- R11: Each flag is a single-cycle pulse in the cycle after the word is accepted. instr_ready is low from acceptance of a store until its handshake completes. After reset, instr_ready is high and st_valid and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word present |
| instr_word | input | 32 | Instruction word |
| instr_ready | output | 1 | Unit idle and able to accept a word |
| rf_base_idx | output | 5 | Base register read index (bits [9:5]) |
| rf_vec_idx | output | 5 | Vector register read index (bits [4:0]) |
| base_data | input | ADDR_W | General register read data for the base |
| vec_data | input | VEC_W | Vector register read data |
| sp_value | input | ADDR_W | Current stack pointer |
| fp_enable | input | 1 | Vector/FP access enabled in current state |
| outstanding_cnt | input | CNT_W | Earlier memory accesses still in flight |
| st_valid | output | 1 | Store request valid |
| st_ready | input | 1 | Store request accepted |
| st_addr | output | ADDR_W | Store byte address |
| st_data | output | VEC_W | Store data, unused upper bits zero |
| st_be | output | VEC_W/8 | Byte enables |
| st_size | output | 3 | Access scale (bytes = 2^scale) |
| st_tag_check | output | 1 | Tag check requested (base not stack pointer) |
| trap_pulse | output | 1 | Vector access disabled |
| undef_pulse | output | 1 | Unallocated size encoding |
| align_fault_pulse | output | 1 | Stack pointer misaligned |

## Verification
The bench builds the unit with its default parameters: 64-bit addresses, 128-bit vector registers, a 4-bit outstanding count and a 16-byte stack alignment. Because the vector width is 128 bits, scale 4 reaches the full 16-byte lane set, and scales 5 to 7 reach the rejected encodings. The 4-bit count lets the bench hold several accesses in flight and watch the request stay parked. The 64-bit address width lets offsets of -256 and +255 wrap across real high-order bits.

// File: rtl/srv_pkg.sv
`timescale 1ns/1ps
package srv_pkg;

    localparam int INSN_W = 32;
    localparam logic [4:0] SP_SEL = 5'd31;

    typedef struct packed {
        logic       hit;
        logic [2:0] scale;
        logic [8:0] imm9;
        logic [4:0] rn;
        logic [4:0] rt;
    } insn_fields_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DRAIN = 2'd1,
        PH_OFFER = 2'd2
    } issue_phase_t;

    typedef enum logic [1:0] {
        OUT_STORE = 2'd0,
        OUT_TRAP  = 2'd1,
        OUT_UNDEF = 2'd2,
        OUT_ALIGN = 2'd3
    } outcome_t;

    function automatic logic insn_matches(input logic [INSN_W-1:0] w);
        return (w[29:24] == 6'b011101) && (w[22:21] == 2'b00) && (w[11:10] == 2'b10);
    endfunction

    function automatic insn_fields_t split_fields(input logic [INSN_W-1:0] w);
        insn_fields_t f;
        f.hit   = insn_matches(w);
        f.scale = {w[23], w[31:30]};
        f.imm9  = w[20:12];
        f.rn    = w[9:5];
        f.rt    = w[4:0];
        return f;
    endfunction

    // Fixed priority: disabled unit, then bad size, then stack misalignment.
    function automatic outcome_t rank_outcome(input logic fp_ok,
                                              input logic illegal,
                                              input logic misaligned);
        if (!fp_ok)          return OUT_TRAP;
        else if (illegal)    return OUT_UNDEF;
        else if (misaligned) return OUT_ALIGN;
        else                 return OUT_STORE;
    endfunction

endpackage

// File: rtl/srv_field_decode.sv
`timescale 1ns/1ps
module srv_field_decode
    import srv_pkg::*;
#(
    parameter int MAX_SCALE = 4
) (
    input  logic [INSN_W-1:0] insn,
    output insn_fields_t      fields,
    output logic              illegal
);
    localparam logic [2:0] SCALE_LIMIT = 3'(MAX_SCALE);

    always_comb begin
        fields  = split_fields(insn);
        illegal = fields.hit && (fields.scale > SCALE_LIMIT);
    end
endmodule

// File: rtl/srv_addr_gen.sv
`timescale 1ns/1ps
module srv_addr_gen
    import srv_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int ALIGN_BITS = 4
) (
    input  logic [4:0]        rn,
    input  logic [8:0]        imm9,
    input  logic [ADDR_W-1:0] base_data,
    input  logic [ADDR_W-1:0] sp_value,
    output logic [ADDR_W-1:0] ea,
    output logic              from_sp,
    output logic              misaligned
);
    localparam int EXT_W = ADDR_W - 9;

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] base;

    always_comb begin
        from_sp    = (rn == SP_SEL);
        offset     = {{EXT_W{imm9[8]}}, imm9};
        base       = from_sp ? sp_value : base_data;
        ea         = base + offset;
        misaligned = from_sp && (|sp_value[ALIGN_BITS-1:0]);
    end
endmodule

// File: rtl/srv_data_lane.sv
`timescale 1ns/1ps
module srv_data_lane #(
    parameter int VEC_W = 128,
    localparam int BE_W = VEC_W / 8
) (
    input  logic [2:0]       scale,
    input  logic [VEC_W-1:0] vec_in,
    output logic [VEC_W-1:0] lane_data,
    output logic [BE_W-1:0]  lane_be
);
    localparam int NB_W = $clog2(BE_W) + 1;

    logic [NB_W-1:0] nbytes;
    assign nbytes = NB_W'(1) << scale;

    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        assign lane_be[g]          = (NB_W'(g) < nbytes);
        assign lane_data[g*8 +: 8] = lane_be[g] ? vec_in[g*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/srv_issue_ctrl.sv
`timescale 1ns/1ps
module srv_issue_ctrl
    import srv_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int VEC_W  = 128,
    parameter int CNT_W  = 4,
    localparam int BE_W  = VEC_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  outcome_t          verdict,
    input  logic [ADDR_W-1:0] ea,
    input  logic [VEC_W-1:0]  lane_data,
    input  logic [BE_W-1:0]   lane_be,
    input  logic [2:0]        scale,
    input  logic              tag_ok,
    input  logic [CNT_W-1:0]  outstanding,
    input  logic              st_ready,
    output logic              idle,
    output logic              st_valid,
    output logic [ADDR_W-1:0] st_addr,
    output logic [VEC_W-1:0]  st_data,
    output logic [BE_W-1:0]   st_be,
    output logic [2:0]        st_size,
    output logic              st_tag_check,
    output logic              trap_pulse,
    output logic              undef_pulse,
    output logic              align_pulse
);
    issue_phase_t phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase        <= PH_IDLE;
            trap_pulse   <= 1'b0;
            undef_pulse  <= 1'b0;
            align_pulse  <= 1'b0;
            st_addr      <= '0;
            st_data      <= '0;
            st_be        <= '0;
            st_size      <= '0;
            st_tag_check <= 1'b0;
        end else begin
            trap_pulse  <= 1'b0;
            undef_pulse <= 1'b0;
            align_pulse <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (take) begin
                        case (verdict)
                            OUT_TRAP:  trap_pulse  <= 1'b1;
                            OUT_UNDEF: undef_pulse <= 1'b1;
                            OUT_ALIGN: align_pulse <= 1'b1;
                            default: begin
                                st_addr      <= ea;
                                st_data      <= lane_data;
                                st_be        <= lane_be;
                                st_size      <= scale;
                                st_tag_check <= tag_ok;
                                phase        <= PH_DRAIN;
                            end
                        endcase
                    end
                end
                PH_DRAIN: begin
                    // Release ordering: wait for earlier accesses to finish.
                    if (outstanding == '0) phase <= PH_OFFER;
                end
                PH_OFFER: begin
                    if (st_ready) phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign idle     = (phase == PH_IDLE);
    assign st_valid = (phase == PH_OFFER);
endmodule

// File: rtl/srv_store_decode.sv
`timescale 1ns/1ps
module srv_store_decode
    import srv_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int VEC_W      = 128,
    parameter int CNT_W      = 4,
    parameter int ALIGN_BITS = 4,
    localparam int BE_W      = VEC_W / 8,
    localparam int MAX_SCALE = $clog2(BE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [31:0]       instr_word,
    output logic              instr_ready,
    output logic [4:0]        rf_base_idx,
    output logic [4:0]        rf_vec_idx,
    input  logic [ADDR_W-1:0] base_data,
    input  logic [VEC_W-1:0]  vec_data,
    input  logic [ADDR_W-1:0] sp_value,
    input  logic              fp_enable,
    input  logic [CNT_W-1:0]  outstanding_cnt,
    output logic              st_valid,
    input  logic              st_ready,
    output logic [ADDR_W-1:0] st_addr,
    output logic [VEC_W-1:0]  st_data,
    output logic [BE_W-1:0]   st_be,
    output logic [2:0]        st_size,
    output logic              st_tag_check,
    output logic              trap_pulse,
    output logic              undef_pulse,
    output logic              align_fault_pulse
);
    insn_fields_t      fields;
    logic              illegal;
    logic [ADDR_W-1:0] ea;
    logic              from_sp;
    logic              misaligned;
    logic [VEC_W-1:0]  lane_data;
    logic [BE_W-1:0]   lane_be;
    logic              idle;
    logic              take;
    outcome_t          verdict;

    srv_field_decode #(.MAX_SCALE(MAX_SCALE)) u_dec (
        .insn    (instr_word),
        .fields  (fields),
        .illegal (illegal)
    );

    srv_addr_gen #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_agen (
        .rn         (fields.rn),
        .imm9       (fields.imm9),
        .base_data  (base_data),
        .sp_value   (sp_value),
        .ea         (ea),
        .from_sp    (from_sp),
        .misaligned (misaligned)
    );

    srv_data_lane #(.VEC_W(VEC_W)) u_lane (
        .scale     (fields.scale),
        .vec_in    (vec_data),
        .lane_data (lane_data),
        .lane_be   (lane_be)
    );

    assign verdict     = rank_outcome(fp_enable, illegal, misaligned);
    assign take        = instr_valid && idle && fields.hit;
    assign instr_ready = idle;
    assign rf_base_idx = fields.rn;
    assign rf_vec_idx  = fields.rt;

    srv_issue_ctrl #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .CNT_W(CNT_W)) u_issue (
        .clk          (clk),
        .rst          (rst),
        .take         (take),
        .verdict      (verdict),
        .ea           (ea),
        .lane_data    (lane_data),
        .lane_be      (lane_be),
        .scale        (fields.scale),
        .tag_ok       (!from_sp),
        .outstanding  (outstanding_cnt),
        .st_ready     (st_ready),
        .idle         (idle),
        .st_valid     (st_valid),
        .st_addr      (st_addr),
        .st_data      (st_data),
        .st_be        (st_be),
        .st_size      (st_size),
        .st_tag_check (st_tag_check),
        .trap_pulse   (trap_pulse),
        .undef_pulse  (undef_pulse),
        .align_pulse  (align_fault_pulse)
    );
endmodule

// File: rtl/srv_checker.sv
`timescale 1ns/1ps
module srv_checker #(
    parameter int ADDR_W     = 64,
    parameter int VEC_W      = 128,
    parameter int CNT_W      = 4,
    parameter int ALIGN_BITS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              instr_valid,
    input logic              instr_ready,
    input logic [4:0]        insn_rn,
    input logic [2:0]        insn_scale,
    input logic [ALIGN_BITS-1:0] sp_low,
    input logic              fp_enable,
    input logic [CNT_W-1:0]  outstanding_cnt,
    input logic              st_valid,
    input logic              st_ready,
    input logic [ADDR_W-1:0] st_addr,
    input logic [VEC_W-1:0]  st_data,
    input logic [VEC_W/8-1:0] st_be,
    input logic [2:0]        st_size,
    input logic              st_tag_check,
    input logic              trap_pulse,
    input logic              undef_pulse,
    input logic              align_fault_pulse
);
    a_r2_be_matches_size: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> ($countones(st_be) == (1 << st_size)));

    a_r3_legal_size_only: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> (st_size <= 3'd4));

    a_r3_undef_cause: assert property (@(posedge clk) disable iff (rst)
        undef_pulse |-> ($past(instr_valid) && ($past(insn_scale) > 3'd4)));

    a_r6_align_cause: assert property (@(posedge clk) disable iff (rst)
        align_fault_pulse |-> ($past(insn_rn) == 5'd31 && $past(sp_low) != '0));

    a_r7_trap_cause: assert property (@(posedge clk) disable iff (rst)
        trap_pulse |-> ($past(instr_valid) && !$past(fp_enable)));

    a_r7_single_flag: assert property (@(posedge clk) disable iff (rst)
        $onehot0({trap_pulse, undef_pulse, align_fault_pulse}));

    a_r8_drained_first: assert property (@(posedge clk) disable iff (rst)
        $rose(st_valid) |-> ($past(outstanding_cnt) == '0));

    a_r9_hold_until_taken: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !st_ready) |=> (st_valid && $stable(st_addr) && $stable(st_data)
                                     && $stable(st_be) && $stable(st_size)
                                     && $stable(st_tag_check)));

    a_r11_busy_while_pending: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> !instr_ready);

    a_r11_no_store_with_flag: assert property (@(posedge clk) disable iff (rst)
        (trap_pulse || undef_pulse || align_fault_pulse) |-> !st_valid);
endmodule

bind srv_store_decode srv_checker #(
    .ADDR_W(ADDR_W), .VEC_W(VEC_W), .CNT_W(CNT_W), .ALIGN_BITS(ALIGN_BITS)
) chk_i (
    .clk               (clk),
    .rst               (rst),
    .instr_valid       (instr_valid),
    .instr_ready       (instr_ready),
    .insn_rn           (instr_word[9:5]),
    .insn_scale        ({instr_word[23], instr_word[31:30]}),
    .sp_low            (sp_value[ALIGN_BITS-1:0]),
    .fp_enable         (fp_enable),
    .outstanding_cnt   (outstanding_cnt),
    .st_valid          (st_valid),
    .st_ready          (st_ready),
    .st_addr           (st_addr),
    .st_data           (st_data),
    .st_be             (st_be),
    .st_size           (st_size),
    .st_tag_check      (st_tag_check),
    .trap_pulse        (trap_pulse),
    .undef_pulse       (undef_pulse),
    .align_fault_pulse (align_fault_pulse)
);

// File: tb/srv_store_decode_tb.sv
`timescale 1ns/1ps
module srv_store_decode_tb_top;
    localparam int ADDR_W = 64;
    localparam int VEC_W  = 128;
    localparam int CNT_W  = 4;
    localparam int BE_W   = VEC_W / 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              instr_valid;
    logic [31:0]       instr_word;
    logic              instr_ready;
    logic [4:0]        rf_base_idx;
    logic [4:0]        rf_vec_idx;
    logic [ADDR_W-1:0] base_data;
    logic [VEC_W-1:0]  vec_data;
    logic [ADDR_W-1:0] sp_value;
    logic              fp_enable;
    logic [CNT_W-1:0]  outstanding_cnt;
    logic              st_valid;
    logic              st_ready;
    logic [ADDR_W-1:0] st_addr;
    logic [VEC_W-1:0]  st_data;
    logic [BE_W-1:0]   st_be;
    logic [2:0]        st_size;
    logic              st_tag_check;
    logic              trap_pulse;
    logic              undef_pulse;
    logic              align_fault_pulse;

    always #4 clk = ~clk;

    srv_store_decode dut_i (.*);

    typedef struct {
        int                kind; // 0 store, 1 trap, 2 undef, 3 align
        logic [ADDR_W-1:0] addr;
        logic [VEC_W-1:0]  data;
        logic [BE_W-1:0]   be;
        logic [2:0]        size;
        logic              tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    task automatic chk(input bit ok, input string req,
                       input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    function automatic logic [31:0] enc(input logic [1:0] sz, input logic hi,
                                       input logic [8:0] imm, input logic [4:0] rn,
                                       input logic [4:0] rt);
        return {sz, 6'b011101, hi, 2'b00, imm, 2'b10, rn, rt};
    endfunction

    // Driver: presents one word for one accepted cycle and queues the expected result.
    task automatic send(input logic [31:0] w, input logic [ADDR_W-1:0] base,
                        input logic [VEC_W-1:0] vec, input logic [ADDR_W-1:0] sp,
                        input logic fpen);
        exp_t e;
        logic [2:0] sc;
        int nb;
        @(posedge clk); #1;
        while (!instr_ready) begin @(posedge clk); #1; end
        instr_word  = w;
        base_data   = base;
        vec_data    = vec;
        sp_value    = sp;
        fp_enable   = fpen;
        instr_valid = 1'b1;
        sc = {w[23], w[31:30]};
        e.kind = 0; e.addr = '0; e.data = '0; e.be = '0; e.size = sc; e.tag = 1'b0;
        if (w[29:24] == 6'b011101 && w[22:21] == 2'b00 && w[11:10] == 2'b10) begin
            if (!fpen) e.kind = 1;
            else if (sc > 3'd4) e.kind = 2;
            else if (w[9:5] == 5'd31 && sp[3:0] != 4'd0) e.kind = 3;
            else begin
                nb = 1 << sc;
                for (int i = 0; i < BE_W; i++) begin
                    e.be[i] = (i < nb);
                    e.data[i*8 +: 8] = (i < nb) ? vec[i*8 +: 8] : 8'h00;
                end
                e.addr = ((w[9:5] == 5'd31) ? sp : base)
                         + {{(ADDR_W-9){w[20]}}, w[20:12]};
                e.tag  = (w[9:5] != 5'd31);
            end
            exp_q.push_back(e);
        end
        @(posedge clk); #1;
        instr_valid = 1'b0;
    endtask

    // Acceptance side: ready one cycle in three so requests stall.
    initial begin
        int rc;
        rc = 0;
        st_ready = 1'b0;
        forever begin
            @(posedge clk); #1;
            rc++;
            st_ready = (rc % 3 == 0);
        end
    end

    // Monitor / scoreboard.
    logic              prev_hold = 1'b0;
    logic              prev_valid = 1'b0;
    logic              prev_ev = 1'b0;
    logic [ADDR_W-1:0] prev_addr;
    logic [VEC_W-1:0]  prev_data;
    logic [CNT_W-1:0]  prev_cnt = '0;

    always @(negedge clk) begin
        if (!rst && !done) begin
            if (trap_pulse || undef_pulse || align_fault_pulse) begin
                int got;
                got = trap_pulse ? 1 : (undef_pulse ? 2 : 3);
                if (prev_ev) chk(1'b0, "R11 flag longer than one cycle", 1, 0);
                if (exp_q.size() == 0) chk(1'b0, "R1 unexpected flag", VEC_W'(got), 0);
                else begin
                    cur = exp_q.pop_front();
                    chk(cur.kind == got, "R7 flag kind (R3/R6 cause)", VEC_W'(got), VEC_W'(cur.kind));
                end
            end
            if (st_valid && !prev_valid)
                chk(prev_cnt == '0, "R8 request raised before drain", VEC_W'(prev_cnt), 0);
            if (prev_hold)
                chk(st_valid && st_addr == prev_addr && st_data == prev_data,
                    "R9 request changed while stalled", VEC_W'(st_addr), VEC_W'(prev_addr));
            if (st_valid && st_ready) begin
                if (exp_q.size() == 0) chk(1'b0, "R1 unexpected store", VEC_W'(st_addr), 0);
                else begin
                    cur = exp_q.pop_front();
                    chk(cur.kind == 0, "R7 store where flag expected", 0, VEC_W'(cur.kind));
                    chk(st_addr == cur.addr, "R4 address", VEC_W'(st_addr), VEC_W'(cur.addr));
                    chk(st_data == cur.data, "R10 data", st_data, cur.data);
                    chk(st_be == cur.be && st_size == cur.size, "R2 size and byte enables",
                        VEC_W'({st_size, st_be}), VEC_W'({cur.size, cur.be}));
                    chk(st_tag_check == cur.tag, "R5 tag flag",
                        VEC_W'(st_tag_check), VEC_W'(cur.tag));
                end
            end
            prev_ev    = trap_pulse || undef_pulse || align_fault_pulse;
            prev_hold  = st_valid && !st_ready;
            prev_valid = st_valid;
            prev_addr  = st_addr;
            prev_data  = st_data;
            prev_cnt   = outstanding_cnt;
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        done = 1;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        report();
    end

    localparam logic [VEC_W-1:0] VA = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F;
    localparam logic [VEC_W-1:0] VB = 128'h01234567_89ABCDEF_FEDCBA98_76543210;
    localparam logic [ADDR_W-1:0] SP_OK  = 64'h0000_7FFF_FFFF_0040;
    localparam logic [ADDR_W-1:0] SP_BAD = 64'h0000_7FFF_FFFF_0048;

    initial begin
        rst = 1'b1; instr_valid = 1'b0; instr_word = '0; base_data = '0;
        vec_data = '0; sp_value = '0; fp_enable = 1'b1; outstanding_cnt = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!st_valid && instr_ready && !trap_pulse && !undef_pulse && !align_fault_pulse,
            "R11 reset state", VEC_W'({st_valid, instr_ready}), VEC_W'(2'b01));

        // Stores at every legal scale, offsets at both ends of the range.
        send(enc(2'd0, 1'b0, 9'd5,    5'd3,  5'd7),  64'h1000, VA, SP_OK, 1'b1);
        send(enc(2'd1, 1'b0, 9'h1FF,  5'd4,  5'd1),  64'h2000, VB, SP_OK, 1'b1);
        send(enc(2'd2, 1'b0, 9'h100,  5'd0,  5'd2),  64'h0000_0000_0000_0080, VA, SP_OK, 1'b1);
        send(enc(2'd3, 1'b0, 9'd255,  5'd30, 5'd31), 64'hFFFF_FFFF_FFFF_FF80, VB, SP_OK, 1'b1);
        send(enc(2'd0, 1'b1, 9'h010,  5'd9,  5'd0),  64'h3000, VA, SP_OK, 1'b1);
        // Stack pointer base, aligned: R5 and R6 no-fault case.
        send(enc(2'd2, 1'b0, 9'h1F0,  5'd31, 5'd5),  64'hDEAD, VB, SP_OK, 1'b1);
        // Misaligned stack pointer but general base: R6 has no effect.
        send(enc(2'd1, 1'b0, 9'd2,    5'd8,  5'd5),  64'h4000, VB, SP_BAD, 1'b1);
        // Misaligned stack pointer base: R6 fault.
        send(enc(2'd3, 1'b0, 9'd0,    5'd31, 5'd5),  64'h4000, VB, SP_BAD, 1'b1);
        // Scales 5 and 7: R3.
        send(enc(2'd1, 1'b1, 9'd0,    5'd1,  5'd1),  64'h5000, VA, SP_OK, 1'b1);
        send(enc(2'd3, 1'b1, 9'd0,    5'd1,  5'd1),  64'h5000, VA, SP_OK, 1'b1);
        // Disabled unit: R7 trap, also beating undef and misalignment.
        send(enc(2'd2, 1'b0, 9'd4,    5'd2,  5'd3),  64'h6000, VA, SP_OK, 1'b0);
        send(enc(2'd2, 1'b1, 9'd4,    5'd31, 5'd3),  64'h6000, VA, SP_BAD, 1'b0);
        // Undef beats misalignment: R7 priority.
        send(enc(2'd1, 1'b1, 9'd4,    5'd31, 5'd3),  64'h6000, VA, SP_BAD, 1'b1);

        // Non-matching words: R1.
        send(enc(2'd2, 1'b0, 9'd4, 5'd2, 5'd3) | 32'h0000_0C00, 64'h7000, VA, SP_OK, 1'b1);
        send(enc(2'd2, 1'b0, 9'd4, 5'd2, 5'd3) ^ 32'h0100_0000, 64'h7000, VA, SP_OK, 1'b1);
        send(enc(2'd2, 1'b0, 9'd4, 5'd2, 5'd3) | 32'h0020_0000, 64'h7000, VA, SP_OK, 1'b1);
        repeat (12) @(negedge clk);
        chk(exp_q.size() == 0 && !st_valid, "R1 non-matching words ignored",
            VEC_W'(exp_q.size()), 0);

        // Release ordering: R8.
        @(posedge clk); #1 outstanding_cnt = 4'd3;
        send(enc(2'd3, 1'b0, 9'd8, 5'd6, 5'd4), 64'h8000, VB, SP_OK, 1'b1);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(!st_valid, "R8 request parked while accesses in flight", VEC_W'(st_valid), 0);
            chk(!instr_ready, "R11 busy while store pending", VEC_W'(instr_ready), 0);
        end
        @(posedge clk); #1 outstanding_cnt = 4'd1;
        @(negedge clk);
        chk(!st_valid, "R8 request parked at count one", VEC_W'(st_valid), 0);
        @(posedge clk); #1 outstanding_cnt = 4'd0;

        for (int k = 0; k < 60 && exp_q.size() != 0; k++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R1 every expected result observed", VEC_W'(exp_q.size()), 0);
        done = 1;
        report();
    end
endmodule